// File: doc/BRIEF.md
# Corrected Min-Sum Check-Node Processor

This block computes the check-to-variable messages of one parity-check row of a low-density parity-check decoder. It works serially and is reused across rows. The variable-to-check messages of a row arrive one per cycle, each a 6-bit two's-complement value. A first marker opens the row and a last marker closes it. While the row streams in, the block keeps three things: the smallest magnitude, the second smallest magnitude with the position of the smallest, and the running XOR of the signs. It never evaluates hyperbolic functions.

Once the last edge has been taken, the block plays back one outgoing message per edge, in input order. Each outgoing magnitude is the smallest magnitude among the other edges of the row. A correction then shrinks that magnitude in one of two ways: it subtracts an offset, or it scales by a factor below one. The mode and its 3-bit parameter are read from a four-entry table. The table is a parameter, and the entry is chosen by a 2-bit channel-quality index that is sampled with the first edge of the row.

Top module: `cnu_minsum`

## Requirements
- R1: After reset, `out_valid` and `out_last` are low until a row has been closed.
- R2: For a row of d edges (1 ≤ d ≤ MAX_DEG), `out_valid` is high on exactly the d cycles that follow the rising edge which accepts the last edge, and `out_last` is high only on the d-th of those cycles.
- R3: With correction entry 0 (offset mode, parameter 0), output j has magnitude equal to the minimum magnitude over all edges of the row other than edge j.
- R4: The sign bit (bit 5) of output j is the XOR of the sign bits of all the other inputs in the row. When the corrected magnitude is zero, the output is 0.
- R5: In offset mode (entry bit 3 = 0), the magnitude is max(m − p, 0), where p is entry bits 2:0.
- R6: In normalized mode (entry bit 3 = 1), the magnitude is floor(m · p / 8).
- R7: An input of −32 is treated as −31 (magnitude 31, sign 1). No output is ever −32.
- R8: The correction entry is taken from nibble `qual_idx` of `CORR_TABLE` (bits 4q+3:4q), sampled with the first edge. Changes to `qual_idx` later in the row have no effect. The default table has entry 0 = offset 0, entry 1 = offset 2, entry 2 = scale 6/8 and entry 3 = scale 5/8.
- R9: Inputs presented while `out_valid` is high are ignored, and they do not disturb the row that is being emitted.
- R10: In a row of one edge, the magnitude before correction is 31.
- R11: When two edges share the smallest magnitude, every output magnitude before correction equals that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input edge message is present |
| in_first | input | 1 | The message is the first edge of a row |
| in_last | input | 1 | The message is the last edge of a row |
| in_msg | input | W | Variable-to-check message, two's complement |
| qual_idx | input | 2 | Channel-quality index that selects the correction entry |
| out_valid | output | 1 | An outgoing check-to-variable message is present |
| out_last | output | 1 | Final outgoing message of the row |
| out_msg | output | W | Corrected check-to-variable message, two's complement |

## Verification
The outgoing message for edge j appears j+1 cycles after the rising edge that takes the last input of the row. The row ends one cycle later, with `out_valid` low. The bench drives every input on a falling edge. It checks each output word, its sign and its last flag at the falling edge that follows each rising edge, so every sample lands in the cycle where that result is due. The sweeps cover every table entry and every row length from 1 to 8. Directed rows cover the clamped most-negative input, tied minima, offset saturation, a quality index that changes mid-row, and input noise during emission.

// File: rtl/cnu_minsum.sv
module cnu_minsum #(
  parameter int W = 6,
  parameter int MAX_DEG = 8,
  parameter logic [15:0] CORR_TABLE = 16'hDE20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_first,
  input  logic         in_last,
  input  logic [W-1:0] in_msg,
  input  logic [1:0]   qual_idx,
  output logic         out_valid,
  output logic         out_last,
  output logic [W-1:0] out_msg
);
  localparam int MW = W - 1;
  localparam int IW = (MAX_DEG > 1) ? $clog2(MAX_DEG) : 1;
  localparam logic [MW-1:0] MAG_MAX = '1;

  logic [MW-1:0]      min1, min2, base1, base2, mag, sel, cmag;
  logic [IW-1:0]      min_idx, pos, last_idx, emit, bidx, bpos;
  logic [MAX_DEG-1:0] sgn;
  logic               sprod, bsp, take, in_sign;
  logic [3:0]         corr;
  logic [MW+2:0]      prod;

  assign take    = in_valid && !out_valid;
  assign in_sign = in_msg[W-1];
  assign mag     = in_sign ? ((in_msg[MW-1:0] == '0) ? MAG_MAX : MW'(-in_msg[MW-1:0]))
                           : in_msg[MW-1:0];

  assign base1 = in_first ? MAG_MAX : min1;
  assign base2 = in_first ? MAG_MAX : min2;
  assign bidx  = in_first ? '0 : min_idx;
  assign bpos  = in_first ? '0 : pos;
  assign bsp   = in_first ? 1'b0 : sprod;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      emit      <= '0;
      pos       <= '0;
      last_idx  <= '0;
      min1      <= MAG_MAX;
      min2      <= MAG_MAX;
      min_idx   <= '0;
      sgn       <= '0;
      sprod     <= 1'b0;
      corr      <= '0;
    end else if (take) begin
      if (mag < base1) begin
        min1    <= mag;
        min2    <= base1;
        min_idx <= bpos;
      end else begin
        min1    <= base1;
        min2    <= (mag < base2) ? mag : base2;
        min_idx <= bidx;
      end
      sgn[bpos] <= in_sign;
      sprod     <= bsp ^ in_sign;
      pos       <= bpos + 1'b1;
      if (in_first) corr <= CORR_TABLE[{qual_idx, 2'b00} +: 4];
      if (in_last) begin
        out_valid <= 1'b1;
        emit      <= '0;
        last_idx  <= bpos;
      end
    end else if (out_valid) begin
      emit <= emit + 1'b1;
      if (out_last) out_valid <= 1'b0;
    end
  end

  assign out_last = out_valid && (emit == last_idx);
  assign sel      = (emit == min_idx) ? min2 : min1;

  assign prod = ({2'b00, sel, 1'b0, 1'b0} & {(MW+3){corr[2]}})
              + ({2'b00, 1'b0, sel, 1'b0} & {(MW+3){corr[1]}})
              + ({2'b00, 1'b0, 1'b0, sel} & {(MW+3){corr[0]}});

  always_comb begin
    if (corr[3]) cmag = prod[MW+2:3];
    else         cmag = (sel > MW'(corr[2:0])) ? sel - MW'(corr[2:0]) : '0;
  end

  assign out_msg = (sprod ^ sgn[emit]) ? W'(-{1'b0, cmag}) : {1'b0, cmag};
endmodule

module cnu_minsum_chk #(parameter int W = 6) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_last,
  input logic         out_valid,
  input logic         out_last,
  input logic [W-1:0] out_msg
);
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid); // R1
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R2
  AST_ROW_START: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_last && !out_valid |=> out_valid); // R2
  AST_EMIT_CONTINUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |=> out_valid); // R2
  AST_NO_MOST_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_msg != {1'b1, {(W-1){1'b0}}}); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid); // R9
endmodule

bind cnu_minsum cnu_minsum_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
  .out_valid(out_valid), .out_last(out_last), .out_msg(out_msg)
);

// File: tb/cnu_minsum_bench.sv
module cnu_minsum_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] TBL = 16'hDE20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [5:0] in_msg = '0;
  logic [1:0] qual_idx = '0;
  logic out_valid, out_last;
  logic [5:0] out_msg;

  int checks = 0, fails = 0, seed = 7;
  int vals [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  cnu_minsum #(.W(6), .MAX_DEG(8), .CORR_TABLE(TBL)) u_cnu_minsum (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_msg(in_msg), .qual_idx(qual_idx),
    .out_valid(out_valid), .out_last(out_last), .out_msg(out_msg));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd6();
    seed = seed * 1103515245 + 12345;
    return int'($signed(seed[21:16]));
  endfunction

  function automatic int ref_out(input int j, input int d, input int q);
    int m, s, mk, e, p, r;
    m = 31; s = 0;
    for (int k = 0; k < d; k++) begin
      if (k != j) begin
        mk = (vals[k] == -32) ? 31 : ((vals[k] < 0) ? -vals[k] : vals[k]);
        if (mk < m) m = mk;
        s = s ^ int'(vals[k] < 0);
      end
    end
    e = (int'(TBL) >> (4 * q)) & 15;
    p = e & 7;
    if (e >= 8) r = (m * p) / 8;
    else        r = (m > p) ? m - p : 0;
    return (s != 0) ? -r : r;
  endfunction

  task automatic send_row(input int d, input int q, input bit swap_q, input bit noise, input string req);
    int exp, act;
    for (int k = 0; k < d; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_first = (k == 0); in_last = (k == d - 1);
      in_msg = vals[k][5:0];
      qual_idx = (k == 0 || !swap_q) ? 2'(q) : 2'(q ^ 3);
    end
    for (int j = 0; j < d; j++) begin
      @(negedge clk);
      exp = ref_out(j, d, q);
      act = int'($signed(out_msg));
      chk(out_valid === 1'b1, "R2 valid", int'(out_valid), 1);
      chk(act == exp, req, act, exp);
      chk(out_msg[5] == (exp < 0), "R4 sign", int'(out_msg[5]), int'(exp < 0));
      chk(out_last === (j == d - 1), "R2 last", int'(out_last), int'(j == d - 1));
      if (noise) begin
        in_valid = 1'b1; in_first = 1'b1; in_last = 1'b1;
        in_msg = 6'(rnd6()); qual_idx = 2'(q ^ 1);
      end else in_valid = 1'b0;
    end
    @(negedge clk);
    chk(out_valid === 1'b0, "R2 end", int'(out_valid), 0);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid === 1'b0 && out_last === 1'b0, "R1 idle", int'(out_valid), 0);
    end

    for (int q = 0; q < 4; q++)
      for (int d = 1; d <= 8; d++)
        for (int r = 0; r < 4; r++) begin
          for (int k = 0; k < 8; k++) vals[k] = rnd6();
          send_row(d, q, 1'b0, 1'b0, (q == 0) ? "R3 magnitude" : (q == 1) ? "R5 offset" : "R6 scale");
        end

    vals = '{-32, 5, -32, 9, 0, 0, 0, 0};
    send_row(4, 0, 1'b0, 1'b0, "R7 clamp");
    send_row(4, 3, 1'b0, 1'b0, "R7 clamp scaled");

    vals = '{6, -3, 12, -3, 20, 0, 0, 0};
    send_row(5, 0, 1'b0, 1'b0, "R11 tie");

    vals = '{-17, 0, 0, 0, 0, 0, 0, 0};
    send_row(1, 0, 1'b0, 1'b0, "R10 single");
    send_row(1, 2, 1'b0, 1'b0, "R10 single scaled");

    vals = '{1, -2, 1, 30, 0, 0, 0, 0};
    send_row(4, 1, 1'b0, 1'b0, "R5 saturate");

    vals = '{13, -25, 7, 19, -11, 4, 0, 0};
    send_row(6, 2, 1'b1, 1'b0, "R8 index held");
    send_row(6, 1, 1'b1, 1'b0, "R8 index held offset");

    vals = '{-9, 14, 22, -8, 0, 0, 0, 0};
    send_row(4, 3, 1'b0, 1'b1, "R9 noise ignored");
    vals = '{3, 27, -31, 10, -6, 8, 2, 17};
    send_row(8, 0, 1'b0, 1'b1, "R9 next row clean");
    send_row(8, 2, 1'b0, 1'b0, "R9 after noise");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule